// File: doc/BRIEF.md
# Input Capture Edge Unit

This block is the capture side of an eight-channel timer. It sits beside a 16-bit free-running counter, which it does not contain, and watches one external pin per channel. Each pin goes through a two-flop synchroniser. The synchronised level is then compared with its value one cycle earlier. When the transition matches the edge set for that channel, the channel stores the counter value in its own 16-bit capture register and raises its bit in the shared flag vector.

Software sets up the block through write strobes. Each channel has a mode bit that selects capture or compare use, a 2-bit edge field, and an interrupt-enable bit. A single fast-clear bit sets how flags are cleared. With fast-clear off, software writes ones to the flag vector. With fast-clear on, reading a channel's capture register clears that channel's flag. One interrupt line is raised while any enabled flag is set.

Top module: `icap_edge_unit`

## Requirements
- R1: After reset the flag vector, every capture register, the interrupt output, all mode bits, all edge fields, all enables and the fast-clear bit are zero.
- R2: A pin level that is present before clock edge k is first seen by edge detection at clock edge k+2. A matching transition therefore updates the capture register and the flag at edge k+2, and at no earlier edge.
- R3: Edge field n is bits [2n+1:2n] of the edge write data. The values mean: 00 = no capture, 01 = capture on a rising edge, 10 = capture on a falling edge, 11 = capture on either edge.
- R4: Mode bit n is bit n of the mode write data. A value of 1 (compare use) stops all capture on channel n. Its flag is then never set by the pin, and its capture register keeps its value.
- R5: On a capture, the register loads the counter value that is on count_i in the same cycle as the detected edge. A later capture overwrites it, whether or not software has read the earlier value.
- R6: A capture on channel n sets bit n of flag_o at the same clock edge.
- R7: irq_o is high exactly when some bit n has both flag_o[n] and enable bit n set. Enable bit n is bit n of the enable write data.
- R8: With fast-clear off, a flag write clears the flags at the positions where the write data holds 1. Positions holding 0 are unaffected.
- R9: With fast-clear on, a read strobe on rd_i clears the flag of the channel chosen by rd_sel_i, and flag writes have no effect.
- R10: If a capture and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R11: rd_data_o always shows the capture register chosen by rd_sel_i. With fast-clear off, a read strobe leaves every flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous channel pins |
| count_i | input | 16 | Free-running counter value |
| mode_wr_i | input | 1 | Write strobe for the mode bits |
| mode_wdata_i | input | 8 | Mode bits, 1 = compare use |
| edge_wr_i | input | 1 | Write strobe for the edge fields |
| edge_wdata_i | input | 16 | Edge fields, two bits per channel |
| ien_wr_i | input | 1 | Write strobe for the interrupt enables |
| ien_wdata_i | input | 8 | Interrupt enable bits |
| fast_wr_i | input | 1 | Write strobe for the fast-clear bit |
| fast_wdata_i | input | 1 | Fast-clear bit value |
| flag_wr_i | input | 1 | Write strobe for the flag vector |
| flag_wdata_i | input | 8 | Flag write data, 1 clears |
| rd_i | input | 1 | Read strobe for a capture register |
| rd_sel_i | input | 3 | Channel whose capture register is read |
| rd_data_o | output | 16 | Selected capture register |
| flag_o | output | 8 | Per-channel flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every write strobe is high for one cycle at a time. They also assume that rd_sel_i names a real channel whenever rd_i is high. The capture-value property assumes count_i is a clean synchronous signal that the property can sample at the capture edge. The stimulus changes every input only on the falling clock edge. It keeps rd_sel_i within 0 to 7 and drives count_i from a counter that steps once per cycle. Pins may change on any cycle, so the events reach the synchroniser, the edge detection and the clear logic in every possible alignment.

// File: rtl/icap_pkg.sv
`timescale 1ns/1ps
package icap_pkg;

  // Edge selection per channel
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_cfg_e;

  // True when the transition prev -> cur matches the configured edge
  function automatic logic edge_hit(edge_cfg_e cfg, logic prev, logic cur);
    case (cfg)
      EDGE_RISE: return ~prev & cur;
      EDGE_FALL: return prev & ~cur;
      EDGE_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icap_sync.sv
`timescale 1ns/1ps
module icap_sync #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] cur_o,
  output logic [NCH-1:0] prev_o
);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[STAGES-1:0], pin_i[n]};
    end

    assign cur_o[n]  = sh[STAGES-1];
    assign prev_o[n] = sh[STAGES];

    // R2
    sync_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prev_o[n] == $past(cur_o[n]));
  end

endmodule

// File: rtl/icap_channel.sv
`timescale 1ns/1ps
module icap_channel
  import icap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  edge_cfg_e     cfg_i,
  input  logic          cmp_mode_i,
  input  logic          cur_i,
  input  logic          prev_i,
  input  logic [CW-1:0] count_i,
  input  logic          clr_i,
  output logic [CW-1:0] cap_o,
  output logic          flag_o,
  output logic          ev_o
);

  assign ev_o = ~cmp_mode_i & edge_hit(cfg_i, prev_i, cur_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (ev_o) cap_o <= count_i;
      flag_o <= ev_o | (flag_o & ~clr_i);
    end
  end

  // R5
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> cap_o == $past(count_i));
  // R6 R10
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> flag_o);
  // R4
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_mode_i |=> $stable(cap_o));
  // R3
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == EDGE_OFF) |=> $stable(cap_o));
  // R8
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/icap_edge_unit.sv
`timescale 1ns/1ps
module icap_edge_unit
  import icap_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  localparam int SELW = $clog2(NCH),
  localparam int EW   = 2 * NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pin_i,
  input  logic [CW-1:0]   count_i,
  input  logic            mode_wr_i,
  input  logic [NCH-1:0]  mode_wdata_i,
  input  logic            edge_wr_i,
  input  logic [EW-1:0]   edge_wdata_i,
  input  logic            ien_wr_i,
  input  logic [NCH-1:0]  ien_wdata_i,
  input  logic            fast_wr_i,
  input  logic            fast_wdata_i,
  input  logic            flag_wr_i,
  input  logic [NCH-1:0]  flag_wdata_i,
  input  logic            rd_i,
  input  logic [SELW-1:0] rd_sel_i,
  output logic [CW-1:0]   rd_data_o,
  output logic [NCH-1:0]  flag_o,
  output logic            irq_o
);

  logic [NCH-1:0] mode_q, ien_q;
  edge_cfg_e      edge_q [NCH];
  logic           fast_q;

  logic [NCH-1:0] sync_cur, sync_prev;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] cap_ev;
  logic [CW-1:0]  cap_arr [NCH];

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
      fast_q <= 1'b0;
      for (int n = 0; n < NCH; n++) edge_q[n] <= EDGE_OFF;
    end else begin
      if (mode_wr_i) mode_q <= mode_wdata_i;
      if (ien_wr_i)  ien_q  <= ien_wdata_i;
      if (fast_wr_i) fast_q <= fast_wdata_i;
      if (edge_wr_i)
        for (int n = 0; n < NCH; n++) edge_q[n] <= edge_cfg_e'(edge_wdata_i[2*n +: 2]);
    end
  end

  // Flag clear requests: read-clears in fast mode, write-one-clears otherwise
  always_comb begin
    clr_vec = '0;
    if (fast_q) begin
      if (rd_i) clr_vec[rd_sel_i] = 1'b1;
    end else if (flag_wr_i) begin
      clr_vec = flag_wdata_i;
    end
  end

  icap_sync #(.NCH(NCH), .STAGES(2)) u_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pin_i  (pin_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    icap_channel #(.CW(CW)) u_chan (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_i      (edge_q[n]),
      .cmp_mode_i (mode_q[n]),
      .cur_i      (sync_cur[n]),
      .prev_i     (sync_prev[n]),
      .count_i    (count_i),
      .clr_i      (clr_vec[n]),
      .cap_o      (cap_arr[n]),
      .flag_o     (flag_o[n]),
      .ev_o       (cap_ev[n])
    );
  end

  assign rd_data_o = cap_arr[rd_sel_i];
  assign irq_o     = |(flag_o & ien_q);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_o & ien_q) == '0) |-> !irq_o);
  // R9
  fast_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && !rd_i) |=> ((~flag_o & $past(flag_o)) == '0));
  // R11
  plain_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_q && !flag_wr_i) |=> ((~flag_o & $past(flag_o)) == '0));
  // R6
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_ev) |=> (|flag_o));

endmodule

// File: tb/icap_edge_unit_bench.sv
`timescale 1ns/1ps
module icap_edge_unit_bench;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  pin_i = '0;
  logic [15:0] count_i = 16'h1000;
  logic mode_wr = 0, edge_wr = 0, ien_wr = 0, fast_wr = 0, flag_wr = 0, rd_i = 0;
  logic [7:0]  mode_wdata = '0, ien_wdata = '0, flag_wdata = '0;
  logic [15:0] edge_wdata = '0;
  logic        fast_wdata = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data_o;
  logic [7:0]  flag_o;
  logic        irq_o;

  always #2 clk = ~clk;

  icap_edge_unit #(.NCH(NCH), .CW(CW)) u_icap_edge_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .count_i(count_i),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .edge_wr_i(edge_wr), .edge_wdata_i(edge_wdata),
    .ien_wr_i(ien_wr), .ien_wdata_i(ien_wdata),
    .fast_wr_i(fast_wr), .fast_wdata_i(fast_wdata),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .rd_i(rd_i), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  int tests = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 0;

  // Behavioural reference model
  logic [7:0]  hist [$];
  logic [7:0]  m_flag, m_mode, m_ien;
  logic        m_fast;
  logic [1:0]  m_cfg [8];
  logic [15:0] m_cap [8];
  logic [7:0]  cur_lvl, old_lvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {8'h00, 8'h00, 8'h00};
      m_flag = 0; m_mode = 0; m_ien = 0; m_fast = 0;
      for (int i = 0; i < 8; i++) begin m_cfg[i] = 0; m_cap[i] = 0; end
    end else begin
      cur_lvl = hist[hist.size()-2];
      old_lvl = hist[hist.size()-3];
      for (int i = 0; i < 8; i++) begin
        bit hit, ev, clr;
        case (m_cfg[i])
          2'd1: hit = !old_lvl[i] && cur_lvl[i];
          2'd2: hit = old_lvl[i] && !cur_lvl[i];
          2'd3: hit = old_lvl[i] != cur_lvl[i];
          default: hit = 0;
        endcase
        ev  = hit && !m_mode[i];
        clr = m_fast ? (rd_i && rd_sel == i) : (flag_wr && flag_wdata[i]);
        m_flag[i] = ev || (m_flag[i] && !clr);
        if (ev) m_cap[i] = count_i;
      end
      if (mode_wr) m_mode = mode_wdata;
      if (ien_wr)  m_ien  = ien_wdata;
      if (fast_wr) m_fast = fast_wdata;
      if (edge_wr) for (int i = 0; i < 8; i++) m_cfg[i] = edge_wdata[2*i +: 2];
      hist.push_back(pin_i);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // One clock: compare on the falling edge, then release strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check({tag, " flags"}, {24'd0, flag_o}, {24'd0, m_flag});
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(m_flag & m_ien)});
    check({tag, " capture"}, {16'd0, rd_data_o}, {16'd0, m_cap[rd_sel]});
    count_i++;
    mode_wr = 0; edge_wr = 0; ien_wr = 0; fast_wr = 0; flag_wr = 0; rd_i = 0;
  endtask

  task automatic sweep();
    for (int s = 0; s < 8; s++) begin rd_sel = 3'(s); tick(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    check("R1 flags at reset", {24'd0, flag_o}, 0);
    check("R1 irq at reset", {31'd0, irq_o}, 0);
    sweep();

    // ch0 rise, ch1 fall, ch2 both, ch3 off, ch4..7 both; ch7 compare use
    mode_wr = 1; mode_wdata = 8'h80;
    edge_wr = 1; edge_wdata = 16'hFF39;
    ien_wr = 1; ien_wdata = 8'h05;
    tick();

    // R3 edge encodings, R4 compare mode idle
    tag = "R3";
    pin_i = 8'hFF; repeat (4) tick();
    check("R3 rising edges", {24'd0, flag_o}, 32'h75);
    pin_i = 8'h00; repeat (4) tick();
    check("R3 falling edges", {24'd0, flag_o}, 32'h77);
    tag = "R4";
    check("R4 compare channel flag", {31'd0, flag_o[7]}, 0);
    sweep();
    check("R7 irq with enabled flag", {31'd0, irq_o}, 1);

    // R8 write-one-to-clear
    tag = "R8";
    flag_wr = 1; flag_wdata = 8'h00; tick();
    check("R8 zero write no effect", {24'd0, flag_o}, 32'h77);
    flag_wr = 1; flag_wdata = 8'h05; tick();
    check("R8 selective clear", {24'd0, flag_o}, 32'h72);
    flag_wr = 1; flag_wdata = 8'hFF; tick();
    check("R8 clear all", {24'd0, flag_o}, 0);
    check("R7 irq low", {31'd0, irq_o}, 0);

    // R2 synchroniser latency
    tag = "R2";
    pin_i[0] = 1'b1;
    tick(); tick();
    check("R2 no flag before third edge", {31'd0, flag_o[0]}, 0);
    tick();
    check("R2 flag at third edge", {31'd0, flag_o[0]}, 1);

    // R10 capture and clear on the same edge
    tag = "R10";
    pin_i[0] = 1'b0; repeat (4) tick();
    flag_wr = 1; flag_wdata = 8'hFF; tick();
    pin_i[0] = 1'b1; tick(); tick();
    flag_wr = 1; flag_wdata = 8'h01; tick();
    check("R10 set wins over clear", {31'd0, flag_o[0]}, 1);

    // R5 overwrite before read
    tag = "R5";
    rd_sel = 3'd2;
    pin_i[2] = 1'b1; repeat (3) tick();
    first = rd_data_o;
    pin_i[2] = 1'b0; repeat (3) tick();
    check("R5 second capture overwrites", {16'd0, rd_data_o}, {16'd0, first + 16'd3});

    // R11 plain read keeps flag
    tag = "R11";
    rd_i = 1; rd_sel = 3'd2; tick();
    check("R11 read keeps flag", {31'd0, flag_o[2]}, 1);

    // R9 fast clear
    tag = "R9";
    fast_wr = 1; fast_wdata = 1'b1; tick();
    flag_wr = 1; flag_wdata = 8'hFF; tick();
    check("R9 flag write ignored", {24'd0, flag_o}, 32'h05);
    rd_i = 1; rd_sel = 3'd2; tick();
    check("R9 read clears channel", {24'd0, flag_o}, 32'h01);
    fast_wr = 1; fast_wdata = 1'b0; tick();

    // R6 mixed random traffic against the model
    tag = "R6";
    for (int c = 0; c < 600; c++) begin
      int r;
      r = $urandom_range(0, 15);
      pin_i = 8'($urandom);
      rd_sel = 3'($urandom_range(0, 7));
      if (r == 0) begin edge_wr = 1; edge_wdata = 16'($urandom); end
      if (r == 1) begin mode_wr = 1; mode_wdata = 8'($urandom) & 8'h81; end
      if (r == 2) begin ien_wr = 1; ien_wdata = 8'($urandom); end
      if (r == 3) begin fast_wr = 1; fast_wdata = 1'($urandom); end
      if (r >= 4 && r <= 6) begin flag_wr = 1; flag_wdata = 8'($urandom); end
      if (r >= 7 && r <= 9) rd_i = 1;
      tick();
    end
    sweep();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule